// File: doc/BRIEF.md
# I2C Packet Queue Front End

This block sits between a pair of 32-bit word queues and an I2C byte engine. Software queues packets into a transmit queue. Each packet is three header words followed by payload words. The front end decodes the header, issues address, write and read commands to the byte engine one at a time, and packs received bytes into a receive queue. Per-packet flags decide what happens to the bus after the last byte. The bus can be stopped, held for a repeated start with a new address, or held so that the next packet's bytes follow with no new address phase.

Eight sticky interrupt flags record data requests, errors, queue misuse and packet completion. Writing ones clears them, and an enable mask gates them onto one interrupt line. A level output reports the queue fill states. Two flush pulses empty either queue. Nothing is taken from the transmit queue while the run enable is low.

Top module: `i2c_pkt_frontend`

## Requirements
- R1: After reset `int_status` is 0, `irq` is 0, `eng_valid` is 0 and `fifo_level` reads DEPTH free transmit entries and 0 receive entries.
- R2: While `go` is low, no header word is taken from the transmit queue and no engine command is issued. Clearing `go` returns the unit to idle after any command in flight completes.
- R3: Header word 1 bits [11:0] hold the byte count minus one. In header word 2, the address command byte is bits [7:1] followed by bit 19 (read select) in bit 0. Normally the address command uses code 0, a start.
- R4: Write payload bytes go out lowest byte of each word first, and the final word may be partly used. `eng_last` marks the final byte. `eng_stop` is set on it only when header word 2 bits 15 and 16 are both clear. Write commands use code 2.
- R5: Read commands (code 3) return bytes that are packed lowest first into receive words. A word is pushed after four bytes or after the final byte, with unused upper bytes zero.
- R6: After a packet with bit 16 set, the next packet's address command uses code 1, a repeated start. After a packet with bit 15 set, the next packet issues no address command.
- R7: A packet whose header word 0 has bit 4 clear causes no engine command. Its write payload words are still drained from the queue.
- R8: Status bit 7 is set at the end of a packet only if header word 2 bit 17 is set. Bit 6 is set at the end of a packet if no transmit words remain.
- R9: A completion with no-ack sets status bit 3, and one with arbitration lost sets bit 2. After either, no further command is issued until `go` is cleared.
- R10: Popping an empty receive queue sets status bit 4, and pushing into a full transmit queue sets bit 5. Neither changes any queue level.
- R11: `int_clr_we` clears the status bits set in `int_clr`, and a set in the same cycle wins. `irq` is high when any status bit is set and enabled in `int_en`.
- R12: `fifo_level` is {free transmit entries[3:0], filled receive entries[3:0]}. `flush_tx` and `flush_rx` empty their queues.
- R13: Status bit 0 sets while the receive queue holds data. Status bit 1 sets while a write packet waits on an empty transmit queue.
- R14: A command is held stable until `eng_done`. A read command is issued only when the receive queue has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| go | input | 1 | Packet processing run enable |
| tx_wr | input | 1 | Push `tx_wdata` into transmit queue |
| tx_wdata | input | 32 | Header or payload word |
| rx_rd | input | 1 | Pop receive queue |
| rx_rdata | output | 32 | Head of receive queue |
| flush_rx | input | 1 | Empty receive queue |
| flush_tx | input | 1 | Empty transmit queue |
| fifo_level | output | 8 | {tx free, rx filled} |
| int_en | input | 8 | Interrupt enable mask |
| int_clr_we | input | 1 | Apply write-one-to-clear |
| int_clr | input | 8 | Status bits to clear |
| int_status | output | 8 | Sticky status flags |
| irq | output | 1 | Masked interrupt |
| eng_valid | output | 1 | Command pending to byte engine |
| eng_op | output | 2 | 0 start+addr, 1 restart+addr, 2 write, 3 read |
| eng_byte | output | 8 | Address or write byte |
| eng_last | output | 1 | Final byte of packet |
| eng_stop | output | 1 | Issue STOP after this byte |
| eng_done | input | 1 | Command completed (one cycle) |
| eng_nack | input | 1 | No-ack seen, valid with `eng_done` |
| eng_arb_lost | input | 1 | Arbitration lost, valid with `eng_done` |
| eng_rdata | input | 8 | Read byte, valid with `eng_done` |

## Verification
The assertions take for granted that the byte engine pulses `eng_done` only while a command is pending, for one cycle per command. They also assume `eng_nack` and `eng_arb_lost` matter only alongside it. The bench engine model meets this by answering each pending command once, after a random delay of zero to two cycles, and by dropping `eng_done` in the following cycle. The checks also assume packets are queued whole and one at a time, with header counts within the queue's reach. The random packets keep to one to nine bytes, so a packet never exceeds the queue depth.

// File: rtl/i2c_pkt_frontend.sv
module i2c_pkt_frontend #(
  parameter int DEPTH = 8,
  parameter int CW = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        tx_wr,
  input  logic [31:0] tx_wdata,
  input  logic        rx_rd,
  output logic [31:0] rx_rdata,
  input  logic        flush_rx,
  input  logic        flush_tx,
  output logic [7:0]  fifo_level,
  input  logic [7:0]  int_en,
  input  logic        int_clr_we,
  input  logic [7:0]  int_clr,
  output logic [7:0]  int_status,
  output logic        irq,
  output logic        eng_valid,
  output logic [1:0]  eng_op,
  output logic [7:0]  eng_byte,
  output logic        eng_last,
  output logic        eng_stop,
  input  logic        eng_done,
  input  logic        eng_nack,
  input  logic        eng_arb_lost,
  input  logic [7:0]  eng_rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_H1, S_H2, S_ADDR, S_DATA, S_SKIP, S_HALT} st_t;
  st_t st;

  logic [31:0] txm [DEPTH];
  logic [31:0] rxm [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW:0] tx_cnt, rx_cnt;
  logic tx_empty, tx_full, rx_empty, rx_full, tx_push, tx_pop, rx_push, rx_pop;
  logic [31:0] tx_head, wbuf, rbuf, rx_word;
  logic [CW-1:0] cnt;
  logic [7:0] addr, set;
  logic [1:0] bidx;
  logic proto, rd, cont, rep, ie, prev_cont, prev_rep, wvalid, err, fin;

  assign tx_empty = tx_cnt == '0;
  assign tx_full  = tx_cnt == FULL;
  assign rx_empty = rx_cnt == '0;
  assign rx_full  = rx_cnt == FULL;
  assign tx_head  = txm[tx_rp];
  assign rx_rdata = rxm[rx_rp];
  assign tx_push  = tx_wr && !tx_full;
  assign rx_pop   = rx_rd && !rx_empty;
  assign fifo_level = {4'(FULL - tx_cnt), 4'(rx_cnt)};
  assign irq = |(int_status & int_en);
  assign err = eng_done && (eng_nack || eng_arb_lost);

  always_comb begin
    tx_pop = 1'b0;
    if (go && !tx_empty)
      case (st)
        S_IDLE, S_H1, S_H2: tx_pop = 1'b1;
        S_DATA: tx_pop = !rd && !wvalid && !eng_valid;
        S_SKIP: tx_pop = !rd;
        default: tx_pop = 1'b0;
      endcase
  end

  assign fin = (st == S_DATA && eng_done && !err && cnt == '0) ||
               (st == S_SKIP && go && (rd || (tx_pop && cnt < CW'(4))));
  assign rx_push = st == S_DATA && rd && eng_done && !err && (bidx == 2'd3 || cnt == '0);

  always_comb begin
    rx_word = rbuf;
    rx_word[bidx*8 +: 8] = eng_rdata;
  end

  always_comb begin
    set = '0;
    set[0] = !rx_empty;
    set[1] = st == S_DATA && go && !rd && !wvalid && !eng_valid && tx_empty;
    set[2] = eng_done && eng_arb_lost;
    set[3] = eng_done && eng_nack;
    set[4] = rx_rd && rx_empty;
    set[5] = tx_wr && tx_full;
    set[6] = fin && (tx_cnt - (AW+1)'(tx_pop)) == '0;
    set[7] = fin && ie;
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= tx_wdata;
    if (rx_push) rxm[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      int_status <= '0;
    end else begin
      int_status <= (int_status & ~(int_clr_we ? int_clr : 8'h00)) | set;
      if (flush_tx) begin
        tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      end else begin
        if (tx_push) tx_wp <= tx_wp + 1'b1;
        if (tx_pop)  tx_rp <= tx_rp + 1'b1;
        tx_cnt <= tx_cnt + (AW+1)'(tx_push) - (AW+1)'(tx_pop);
      end
      if (flush_rx) begin
        rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      end else begin
        if (rx_push) rx_wp <= rx_wp + 1'b1;
        if (rx_pop)  rx_rp <= rx_rp + 1'b1;
        rx_cnt <= rx_cnt + (AW+1)'(rx_push) - (AW+1)'(rx_pop);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; proto <= 1'b0; cnt <= '0; addr <= '0;
      {rd, cont, rep, ie, prev_cont, prev_rep, wvalid} <= '0;
      wbuf <= '0; rbuf <= '0; bidx <= '0;
      eng_valid <= 1'b0; eng_op <= '0; eng_byte <= '0; eng_last <= 1'b0; eng_stop <= 1'b0;
    end else if (!go && !eng_valid) begin
      st <= S_IDLE; prev_cont <= 1'b0; prev_rep <= 1'b0;
      wvalid <= 1'b0; bidx <= '0; rbuf <= '0;
    end else begin
      if (eng_done) eng_valid <= 1'b0;
      case (st)
        S_IDLE: if (tx_pop) begin proto <= tx_head[4]; st <= S_H1; end
        S_H1: if (tx_pop) begin cnt <= tx_head[CW-1:0]; st <= S_H2; end
        S_H2: if (tx_pop) begin
          addr <= {tx_head[7:1], tx_head[19]};
          rd <= tx_head[19]; cont <= tx_head[15]; rep <= tx_head[16]; ie <= tx_head[17];
          st <= !proto ? S_SKIP : prev_cont ? S_DATA : S_ADDR;
        end
        S_ADDR:
          if (eng_done) st <= err ? S_HALT : S_DATA;
          else if (go && !eng_valid) begin
            eng_valid <= 1'b1; eng_op <= prev_rep ? 2'd1 : 2'd0; eng_byte <= addr;
            eng_last <= 1'b0; eng_stop <= 1'b0;
          end
        S_DATA:
          if (eng_done) begin
            if (err) st <= S_HALT;
            else begin
              cnt <= cnt - 1'b1;
              bidx <= bidx + 1'b1;
              if (bidx == 2'd3 || cnt == '0) wvalid <= 1'b0;
              rbuf <= rx_push ? 32'h0 : rx_word;
              if (fin) begin
                st <= S_IDLE; bidx <= '0; prev_cont <= cont; prev_rep <= rep;
              end
            end
          end else if (go && !eng_valid) begin
            if (rd) begin
              if (!rx_full) begin
                eng_valid <= 1'b1; eng_op <= 2'd3; eng_byte <= 8'h00;
                eng_last <= cnt == '0; eng_stop <= cnt == '0 && !cont && !rep;
              end
            end else if (wvalid) begin
              eng_valid <= 1'b1; eng_op <= 2'd2; eng_byte <= wbuf[bidx*8 +: 8];
              eng_last <= cnt == '0; eng_stop <= cnt == '0 && !cont && !rep;
            end else if (tx_pop) begin
              wbuf <= tx_head; wvalid <= 1'b1;
            end
          end
        S_SKIP:
          if (fin) st <= S_IDLE;
          else if (tx_pop) cnt <= cnt - CW'(4);
        default: ;
      endcase
    end

  // R14
  eng_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_done |=> eng_valid && $stable(eng_op) && $stable(eng_byte) && $stable(eng_stop));
  // R14
  rd_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_valid) && eng_op == 2'd3 |-> rx_cnt != FULL);
  // R2
  go_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_valid) |-> $past(go));
  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_HALT |-> !eng_valid);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && tx_full && !flush_tx && !tx_pop |=> int_status[5] && $stable(tx_cnt));
  // R12
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL && rx_cnt <= FULL);
endmodule

// File: tb/tb_i2c_pkt_frontend.sv
`timescale 1ns/1ps
module tb_i2c_pkt_frontend;
  logic clk = 0, rst_n = 0, go = 0, tx_wr = 0, rx_rd = 0, flush_rx = 0, flush_tx = 0;
  logic [31:0] tx_wdata = 0, rx_rdata;
  logic [7:0] fifo_level, int_en = 0, int_clr = 0, int_status, eng_byte, eng_rdata = 0;
  logic int_clr_we = 0, irq, eng_valid, eng_last, eng_stop;
  logic eng_done = 0, eng_nack = 0, eng_arb_lost = 0;
  logic [1:0] eng_op;

  always #4 clk = ~clk;

  i2c_pkt_frontend dut (.*);

  int checks = 0, fails = 0, nlog = 0, nack_at = -1, rdseq = 0, dly = 0;
  logic [11:0] oplog [256];
  bit prev_rep = 0;

  initial forever begin
    @(posedge clk); #1;
    eng_done = 0; eng_nack = 0;
    if (eng_valid) begin
      if (dly == 0) begin
        oplog[nlog[7:0]] = {eng_op, eng_byte, eng_last, eng_stop};
        if (nlog == nack_at) eng_nack = 1;
        nlog++;
        if (eng_op == 2'd3) begin eng_rdata = 8'hA0 + 8'(rdseq); rdseq++; end
        eng_done = 1;
        dly = $urandom % 3;
      end else dly--;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask
  task automatic push(input logic [31:0] w);
    @(negedge clk); tx_wr = 1; tx_wdata = w; @(negedge clk); tx_wr = 0;
  endtask
  task automatic hdr(input bit i2c, input int n, input logic [31:0] h2);
    push(i2c ? 32'h10 : 32'h0); push(32'(n - 1)); push(h2);
  endtask
  task automatic clr_all;
    @(negedge clk); int_clr_we = 1; int_clr = 8'hFF; @(negedge clk); int_clr_we = 0;
  endtask
  task automatic op_chk(input int i, input logic [1:0] op, input logic [7:0] b, input bit l, input bit s, input string req);
    chk(oplog[i] == {op, b, l, s}, req, 32'(oplog[i]), 32'({op, b, l, s}));
  endtask

  initial begin
    logic [7:0] bytes [12];
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(int_status == 0 && !irq && !eng_valid, "R1", {int_status, 7'd0, irq, 7'd0, eng_valid}, 0);
    chk(fifo_level == 8'h80, "R1", fifo_level, 8'h80);

    // R2: go low holds queue
    hdr(1, 1, 32'h0002_0050); push(32'h11);
    repeat (20) @(negedge clk);
    chk(nlog == 0 && fifo_level == 8'h40, "R2", {nlog[23:0], fifo_level}, 32'h40);
    go = 1; repeat (60) @(negedge clk);
    // R3 R4 R8
    chk(nlog == 2, "R3", nlog, 2);
    op_chk(0, 2'd0, 8'h50, 0, 0, "R3");
    op_chk(1, 2'd2, 8'h11, 1, 1, "R4");
    chk(int_status[7] && int_status[6], "R8", int_status, 8'hC0);
    // R11
    int_en = 8'h80; @(negedge clk);
    chk(irq == 1, "R11", irq, 1);
    int_en = 8'h04; @(negedge clk);
    chk(irq == 0, "R11", irq, 0);
    @(negedge clk); int_clr_we = 1; int_clr = 8'h80; @(negedge clk); int_clr_we = 0;
    chk(int_status[7:6] == 2'b01, "R11", int_status, 8'h40);
    clr_all;

    // R4 R6 R8: random writes
    for (int p = 0; p < 6; p++) begin
      int n; logic [7:0] a; bit rep;
      n = 1 + $urandom % 9; a = 8'(($urandom % 128) << 1); rep = (p == 2);
      for (int k = 0; k < 12; k++) bytes[k] = (k < n) ? 8'($urandom) : 8'h00;
      nlog = 0;
      hdr(1, n, {15'd0, rep, 8'd0, a});
      for (int w = 0; w < (n + 3) / 4; w++)
        push({bytes[4*w+3], bytes[4*w+2], bytes[4*w+1], bytes[4*w]});
      repeat (80) @(negedge clk);
      chk(nlog == n + 1, "R4", nlog, n + 1);
      op_chk(0, prev_rep ? 2'd1 : 2'd0, a, 0, 0, "R6");
      for (int k = 0; k < n; k++)
        op_chk(k + 1, 2'd2, bytes[k], k == n - 1, k == n - 1 && !rep, "R4");
      chk(int_status[6] && !int_status[7], "R8", int_status, 8'h40);
      prev_rep = rep;
      clr_all;
    end

    // R5 R13 R12: read 6 bytes
    nlog = 0; rdseq = 0;
    hdr(1, 6, 32'h0008_0050);
    repeat (80) @(negedge clk);
    op_chk(0, 2'd0, 8'h51, 0, 0, "R3");
    op_chk(6, 2'd3, 8'h00, 1, 1, "R5");
    chk(fifo_level == 8'h82, "R12", fifo_level, 8'h82);
    chk(int_status[0], "R13", int_status, 1);
    chk(rx_rdata == 32'hA3A2A1A0, "R5", rx_rdata, 32'hA3A2A1A0);
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
    chk(rx_rdata == 32'h0000A5A4, "R5", rx_rdata, 32'h0000A5A4);
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
    clr_all;
    // R10 underflow
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
    chk(int_status[4] && fifo_level == 8'h80, "R10", {int_status, fifo_level}, 32'h1080);
    // R12 flush rx
    hdr(1, 3, 32'h0008_0050);
    repeat (50) @(negedge clk);
    chk(fifo_level == 8'h81, "R12", fifo_level, 8'h81);
    @(negedge clk); flush_rx = 1; @(negedge clk); flush_rx = 0;
    chk(fifo_level == 8'h80, "R12", fifo_level, 8'h80);
    clr_all;

    // R6 continuation
    nlog = 0;
    hdr(1, 2, 32'h0000_8040); push(32'h0000_2211);
    hdr(1, 2, 32'h0000_0040); push(32'h0000_4433);
    repeat (100) @(negedge clk);
    chk(nlog == 5, "R6", nlog, 5);
    op_chk(2, 2'd2, 8'h22, 1, 0, "R6");
    op_chk(3, 2'd2, 8'h33, 0, 0, "R6");
    op_chk(4, 2'd2, 8'h44, 1, 1, "R6");
    clr_all;

    // R7 non-I2C protocol
    nlog = 0;
    hdr(0, 5, 32'h0002_0040); push(32'h1); push(32'h2);
    repeat (40) @(negedge clk);
    chk(nlog == 0 && fifo_level == 8'h80, "R7", {nlog[23:0], fifo_level}, 32'h80);
    chk(int_status[7], "R8", int_status, 8'h80);
    clr_all;

    // R13 tx data request
    nlog = 0;
    hdr(1, 2, 32'h0000_0040);
    repeat (30) @(negedge clk);
    chk(int_status[1] && nlog == 1, "R13", {int_status, nlog[23:0]}, 32'h0200_0001);
    push(32'h0000_BBAA);
    repeat (30) @(negedge clk);
    chk(nlog == 3, "R13", nlog, 3);
    clr_all;

    // R9 nack
    nlog = 0; nack_at = 2;
    hdr(1, 4, 32'h0000_0040); push(32'h4433_2211);
    repeat (60) @(negedge clk);
    chk(nlog == 3 && int_status[3], "R9", {int_status, nlog[23:0]}, 32'h0800_0003);
    nack_at = -1;
    hdr(1, 1, 32'h0000_0040); push(32'h5);
    repeat (40) @(negedge clk);
    chk(nlog == 3, "R9", nlog, 3);
    go = 0; @(negedge clk); flush_tx = 1; @(negedge clk); flush_tx = 0;
    chk(fifo_level == 8'h80, "R12", fifo_level, 8'h80);
    clr_all;

    // R10 overflow
    for (int i = 0; i < 9; i++) push(32'(i));
    chk(int_status[5] && fifo_level == 8'h00, "R10", {int_status, fifo_level}, 32'h2000);
    @(negedge clk); flush_tx = 1; @(negedge clk); flush_tx = 0;
    chk(fifo_level == 8'h80, "R12", fifo_level, 8'h80);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule